// File: doc/BRIEF.md
# Per-Core Interrupt Timer with Countdown and Deadline Modes

A timer that sits beside one processor core and raises a one-cycle interrupt request that carries a programmed vector. Software picks one of three behaviours through a two-bit mode field. One-shot counts down once from a loaded value. Periodic counts down and reloads. Deadline raises the request when a free-running 64-bit timestamp input reaches an absolute target. The countdown modes step once every 2^d bus clock cycles, where d is a programmable divide code.

Software reaches the timer through a flat register port. The port has a write strobe, a 3-bit address and a 64-bit write data bus, and its read data is combinational from the address. The deadline register only works in deadline mode. In any other mode it reads as zero and drops writes. A mask bit lets an expiry latch a pending flag while holding the request line low.

Top module: `core_irq_timer`

## Requirements
- R1: After reset every register reads zero, the mode is one-shot and `irq_valid` is low.
- R2: Register addresses are 0 control, 1 initial count, 2 current count (read only), 3 divide code in bits 2:0, and 4 deadline. Addresses 5 to 7 read zero. The control register fields are vector in bits 7:0, pending in bit 12 (read only), mask in bit 16 and mode in bits 18:17. The mode encodings are 00 one-shot, 01 periodic, 10 deadline and 11 reserved, which stays disarmed.
- R3: In one-shot mode, writing a nonzero initial count N with divide code d starts a countdown. `irq_valid` is high for exactly the one cycle that follows the (N·2^d)-th rising edge after the write edge, and `irq_vector` then equals the control vector. The current count then stays at zero.
- R4: In periodic mode the expiry repeats every N·2^d cycles, and the current count reloads to N on each expiry edge.
- R5: Writing an initial count of zero in one-shot or periodic mode starts no countdown, and the current count reads zero. In deadline or reserved mode, an initial count write is stored but starts nothing.
- R6: Outside deadline mode, the deadline register reads zero and a write to it does not change the stored value.
- R7: In deadline mode, a nonzero deadline write arms the timer and replaces any earlier target. The request fires in the cycle after the first edge at which the timestamp is greater than or equal to the target, and it fires once.
- R8: A deadline write of zero leaves the timer disarmed, and no request follows.
- R9: A deadline write whose value is at or below the current timestamp fires in the cycle right after the write edge.
- R10: Each expiry sets the pending bit. Starting the timer clears it. Starting means a nonzero initial count write in one-shot or periodic mode, or any deadline write in deadline mode.
- R11: When the mask bit is set, an expiry still sets the pending bit but `irq_valid` stays low.
- R12: A control write that changes the mode field disarms the timer. While in deadline mode the current count reads zero.
- R13: An initial count write that lands on the same edge as a countdown expiry takes priority. No request is raised, pending stays clear, and the countdown restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Register read data, combinational from `addr` |
| tsc | input | 64 | Free-running timestamp counter |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request, zero otherwise |

## Verification
The countdown expiry and a software restart through the initial count register can fall on the same clock edge. The bench provokes this by arming a periodic count of 3 and then timing a second initial count write so that it lands exactly on the third edge. The result is judged at the next falling edge: no request, a cleared pending bit and the new count loaded. A second request must then arrive exactly five cycles later.

// File: rtl/core_irq_timer.sv
`timescale 1ns/1ps
module core_irq_timer #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [TS_W-1:0]  wr_data,
  output logic [TS_W-1:0]  rd_data,
  input  logic [TS_W-1:0]  tsc,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_INIT = 3'd1, A_CUR = 3'd2, A_DIV = 3'd3, A_DL = 3'd4;
  localparam logic [1:0] M_ONE = 2'b00, M_PER = 2'b01, M_DL = 2'b10;

  logic [1:0]       mode_q;
  logic             mask_q, pend_q, run_q, armed_q;
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [DIV_W-1:0] div_q;
  logic [TS_W-1:0]  dl_q;
  logic [PRE_W-1:0] presc_q;

  wire mode_cd  = (mode_q == M_ONE) || (mode_q == M_PER);
  wire mode_dl  = (mode_q == M_DL);
  wire w_ctrl   = wr_en && addr == A_CTRL;
  wire w_init   = wr_en && addr == A_INIT;
  wire w_div    = wr_en && addr == A_DIV;
  wire w_dl     = wr_en && addr == A_DL && mode_dl;
  wire mode_chg = w_ctrl && (wr_data[18:17] != mode_q);
  wire init_nz  = wr_data[CNT_W-1:0] != '0;
  wire cd_start = w_init && mode_cd && init_nz;

  wire [PRE_W-1:0] fmax = PRE_W'((1 << div_q) - 1);
  wire tick     = run_q && (presc_q >= fmax);
  wire cd_fire  = tick && (cur_q == CNT_W'(1)) && !w_init && !mode_chg;
  wire dl_now   = w_dl && (wr_data != '0) && (wr_data <= tsc);
  wire dl_fire  = (armed_q && (tsc >= dl_q) && !w_dl && !mode_chg) || dl_now;
  wire fire     = cd_fire || dl_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ONE; mask_q <= 1'b0; vec_q <= '0; pend_q <= 1'b0;
      init_q <= '0; cur_q <= '0; div_q <= '0; dl_q <= '0;
      run_q <= 1'b0; armed_q <= 1'b0; presc_q <= '0;
      irq_valid <= 1'b0; irq_vector <= '0;
    end else begin
      irq_valid  <= fire && !mask_q;
      irq_vector <= (fire && !mask_q) ? vec_q : '0;

      if (fire) pend_q <= 1'b1;
      else if (cd_start || w_dl) pend_q <= 1'b0;

      if (tick) begin
        presc_q <= '0;
        if (cur_q == CNT_W'(1)) begin
          if (mode_q == M_PER) cur_q <= init_q;
          else begin
            cur_q <= '0;
            run_q <= 1'b0;
          end
        end else cur_q <= cur_q - 1'b1;
      end else if (run_q) presc_q <= presc_q + 1'b1;

      if (dl_fire) armed_q <= 1'b0;

      if (w_ctrl) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[16];
        mode_q <= wr_data[18:17];
        if (mode_chg) begin
          run_q <= 1'b0; armed_q <= 1'b0; cur_q <= '0; presc_q <= '0;
        end
      end

      if (w_div) div_q <= wr_data[DIV_W-1:0];

      if (w_init) begin
        init_q <= wr_data[CNT_W-1:0];
        if (mode_cd) begin
          cur_q   <= wr_data[CNT_W-1:0];
          presc_q <= '0;
          run_q   <= init_nz;
        end
      end

      if (w_dl) begin
        dl_q    <= wr_data;
        armed_q <= (wr_data != '0) && !(wr_data <= tsc);
      end
    end
  end

  logic [TS_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[VEC_W-1:0] = vec_q;
    ctrl_rd[12]    = pend_q;
    ctrl_rd[16]    = mask_q;
    ctrl_rd[18:17] = mode_q;
    case (addr)
      A_CTRL:  rd_data = ctrl_rd;
      A_INIT:  rd_data = TS_W'(init_q);
      A_CUR:   rd_data = mode_cd ? TS_W'(cur_q) : '0;
      A_DIV:   rd_data = TS_W'(div_q);
      A_DL:    rd_data = mode_dl ? dl_q : '0;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/core_irq_timer_chk.sv
`timescale 1ns/1ps
module core_irq_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [63:0] wr_data,
  input logic [63:0] tsc,
  input logic        irq_valid,
  input logic [1:0]  mode,
  input logic        mask,
  input logic        run,
  input logic        armed,
  input logic        pend,
  input logic [63:0] dl
);
  AST_MASK_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask)); // R11
  AST_DL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && mode != 2'b10) |=> $stable(dl)); // R6
  AST_ZERO_INIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !mode[1] && wr_data[31:0] == 32'd0) |=> !run); // R5
  AST_DL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && mode == 2'b10 && wr_data == 64'd0) |=> (!armed && !irq_valid)); // R8
  AST_MODE_CHANGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wr_data[18:17] != mode) |=> (!run && !armed && !irq_valid)); // R12
  AST_LATE_DL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && mode == 2'b10 && wr_data != 64'd0 && wr_data <= tsc) |=> (pend && !armed)); // R9
  AST_START_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !mode[1] && wr_data[31:0] != 32'd0) |=> (!pend && run)); // R10
endmodule

bind core_irq_timer core_irq_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .tsc(tsc), .irq_valid(irq_valid), .mode(mode_q), .mask(mask_q),
  .run(run_q), .armed(armed_q), .pend(pend_q), .dl(dl_q)
);

// File: tb/tb_core_irq_timer.sv
`timescale 1ns/1ps
module tb_core_irq_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [63:0] wr_data = '0, tsc = 64'd1000, rd_data;
  logic irq_valid;
  logic [7:0] irq_vector;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_irq_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tsc(tsc), .irq_valid(irq_valid), .irq_vector(irq_vector));

  // {tag, write, addr, data}; reads compare rd_data with data
  localparam int NV = 19;
  localparam logic [75:0] TBL [NV] = '{
    {8'd2,  1'b1, 3'd0, 64'h10025},  // R2 ctrl: mask, vector 0x25, one-shot
    {8'd2,  1'b0, 3'd0, 64'h10025},  // R2
    {8'd6,  1'b1, 3'd4, 64'h777},    // R6 ignored outside deadline
    {8'd6,  1'b0, 3'd4, 64'h0},      // R6
    {8'd2,  1'b1, 3'd3, 64'h5},      // R2 divide code
    {8'd2,  1'b0, 3'd3, 64'h5},      // R2
    {8'd5,  1'b1, 3'd1, 64'h0},      // R5 zero count
    {8'd5,  1'b0, 3'd2, 64'h0},      // R5
    {8'd12, 1'b1, 3'd0, 64'h50025},  // R12 switch to deadline
    {8'd6,  1'b0, 3'd4, 64'h0},      // R6 earlier write not stored
    {8'd7,  1'b1, 3'd4, 64'h5000},   // R7 arm far target
    {8'd7,  1'b0, 3'd4, 64'h5000},   // R7
    {8'd10, 1'b0, 3'd0, 64'h50025},  // R10 pending clear
    {8'd5,  1'b1, 3'd1, 64'h9},      // R5 stored, no start
    {8'd12, 1'b0, 3'd2, 64'h0},      // R12 current reads zero
    {8'd5,  1'b0, 3'd1, 64'h9},      // R5
    {8'd2,  1'b1, 3'd0, 64'h70025},  // R2 reserved mode
    {8'd6,  1'b0, 3'd4, 64'h0},      // R6
    {8'd2,  1'b0, 3'd7, 64'h0}       // R2 unused address
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
    addr = a; #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic irq(input logic v, input logic [7:0] vec, input string tag);
    chk(tag, {55'd0, irq_valid, irq_vector}, {55'd0, v, vec});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; tsc = 64'd1000;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int a = 0; a < 8; a++) rd(3'(a), 64'd0, "R1 register after reset");
    irq(1'b0, 8'h0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][67]) wr(TBL[i][66:64], TBL[i][63:0]);
      else rd(TBL[i][66:64], TBL[i][63:0], $sformatf("R%0d table row %0d", TBL[i][75:68], i));
      irq(1'b0, 8'h0, "R6 no irq during table");
    end

    // R3 one-shot, divide code 1, count 3 -> 6 cycles
    do_reset();
    wr(3'd0, 64'h33);
    wr(3'd3, 64'd1);
    wr(3'd1, 64'd3);
    rd(3'd2, 64'd3, "R3 count loaded");
    step(2); rd(3'd2, 64'd2, "R3 count after two cycles");
    step(3); irq(1'b0, 8'h0, "R3 no early irq");
    step(1); irq(1'b1, 8'h33, "R3 expiry");
    step(1); irq(1'b0, 8'h0, "R3 single pulse");
    rd(3'd2, 64'd0, "R3 stopped at zero");
    rd(3'd0, 64'h1033, "R10 pending set");
    step(8); irq(1'b0, 8'h0, "R3 no repeat");

    // R4 periodic, divide 0, count 4
    wr(3'd0, 64'h20044);
    wr(3'd3, 64'd0);
    wr(3'd1, 64'd4);
    rd(3'd0, 64'h20044, "R10 start clears pending");
    step(3); irq(1'b0, 8'h0, "R4 before first");
    step(1); irq(1'b1, 8'h44, "R4 first expiry");
    rd(3'd2, 64'd4, "R4 reload");
    step(1); irq(1'b0, 8'h0, "R4 gap");
    step(3); irq(1'b1, 8'h44, "R4 second expiry");

    // R13 collision: periodic 3, rewrite on expiry edge
    wr(3'd1, 64'd3);
    step(2);
    wr(3'd1, 64'd5);
    irq(1'b0, 8'h0, "R13 expiry dropped");
    rd(3'd0, 64'h20044, "R13 pending clear");
    rd(3'd2, 64'd5, "R13 new count");
    step(4); irq(1'b0, 8'h0, "R13 before restart expiry");
    step(1); irq(1'b1, 8'h44, "R13 restart expiry");

    // R11 mask
    wr(3'd0, 64'h10055);
    wr(3'd1, 64'd2);
    irq(1'b0, 8'h0, "R11 masked a");
    step(1); irq(1'b0, 8'h0, "R11 masked b");
    step(1); irq(1'b0, 8'h0, "R11 masked c");
    rd(3'd0, 64'h11055, "R11 pending still set");

    // R12 mode change disarms
    wr(3'd0, 64'h20066);
    wr(3'd1, 64'd3);
    wr(3'd0, 64'h00066);
    for (int i = 0; i < 6; i++) begin
      irq(1'b0, 8'h0, "R12 disarmed");
      step(1);
    end
    rd(3'd2, 64'd0, "R12 count cleared");

    // R7 deadline
    wr(3'd0, 64'h40077);
    wr(3'd4, 64'd1010);
    irq(1'b0, 8'h0, "R7 armed quiet");
    tsc = 64'd1009; step(1); irq(1'b0, 8'h0, "R7 below target");
    tsc = 64'd1010; step(1); irq(1'b1, 8'h77, "R7 reached");
    tsc = 64'd1020; step(1); irq(1'b0, 8'h0, "R7 fires once");
    rd(3'd0, 64'h41077, "R10 deadline pending");
    tsc = 64'd1000;
    wr(3'd4, 64'd1100);
    wr(3'd4, 64'd1200);
    rd(3'd0, 64'h40077, "R10 deadline write clears pending");
    tsc = 64'd1150; step(1); irq(1'b0, 8'h0, "R7 old target cancelled");
    tsc = 64'd1200; step(1); irq(1'b1, 8'h77, "R7 new target");

    // R9 target already passed
    tsc = 64'd2000;
    wr(3'd4, 64'd1500);
    irq(1'b1, 8'h77, "R9 immediate expiry");
    step(1); irq(1'b0, 8'h0, "R9 single pulse");

    // R8 zero deadline
    wr(3'd4, 64'd0);
    for (int i = 0; i < 4; i++) begin
      irq(1'b0, 8'h0, "R8 zero target quiet");
      tsc = tsc + 64'd100;
      step(1);
    end
    rd(3'd0, 64'h40077, "R8 pending clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule